// File: doc/BRIEF.md
# Edge-Triggered Bit Shift Register

A bit-serial shift register of configurable length (five bits by default) that advances by exactly one position for each low-to-high transition of a level control input, called the step request. Holding the request high does not cause repeated shifts. A new shift needs the request to go low and then high again.

On each shift a new bit is taken from the serial input. The bit pushed out at the far end is kept in a separate unload flag until the next shift. The whole register is always visible as a parallel word.

A compile-time parameter selects the direction:

- **Right shift:** the new bit enters at the MSB and moves toward bit 0. Bit 0 is ejected into the unload flag.
- **Left shift:** the new bit enters at bit 0 and moves toward the MSB. The MSB is ejected into the unload flag.

Top module: `edge_bit_shifter`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the parallel word, the unload flag and the stored previous value of the step request. Consequently, a request held high while reset is released produces one shift at the first edge after reset.
- R2: With SHIFT_LEFT=0, a shift performs three moves at the same clock edge:
  - bit 0 of the word moves to the unload flag;
  - each bit i takes bit i+1;
  - the MSB (bit WIDTH-1) takes serialIn.
- R3: With SHIFT_LEFT=1, a shift performs three moves at the same clock edge:
  - the MSB moves to the unload flag;
  - each bit i takes bit i-1;
  - bit 0 takes serialIn.
- R4: A shift occurs at the clock edge where stepReq is sampled 1 and its value sampled at the previous edge was 0. Keeping stepReq at 1 over any number of further edges causes no additional shift.
- R5: At an edge where no shift occurs, serialIn has no effect on the parallel word.
- R6: A bit loaded from serialIn appears at the unload flag on the WIDTH-th shift after the one that loaded it, and not earlier.
- R7: The unload flag keeps its value at every edge where no shift occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stepReq | input | 1 | Level step request; a 0-to-1 change causes one shift |
| serialIn | input | 1 | Bit inserted at the entry end on a shift |
| parWord | output | WIDTH | Current register contents, bit 0 = LSB |
| unloadBit | output | 1 | Last bit ejected from the exit end |

## Verification
A stuck or stale edge history would show at the ports as one of two faults:
- a missed shift, visible at the next edge after a new request;
- an extra shift while the request is held, visible one edge after the first shift.

A wrong datapath index shows on parWord at the very shift that misroutes a bit, often long before that bit reaches unloadBit. The bench therefore compares the full word after every edge, not only the unload flag. The five-edge latency is checked separately, so that an off-by-one in the chain length cannot hide.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic clear;  // synchronous clear of all datapath state
    logic shift;  // advance one position this edge
  } bsrStrobe_t;
endpackage

// File: rtl/bsr_control.sv
module bsr_control
  import bsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stepReq,
  output bsrStrobe_t strobe
);
  logic stepPrev;

  always_ff @(posedge clk) begin
    if (rst) stepPrev <= 1'b0;
    else     stepPrev <= stepReq;
  end

  always_comb begin
    strobe.clear = rst;
    strobe.shift = !rst && stepReq && !stepPrev;
  end

  // R4
  single_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.shift && stepReq) |=> !strobe.shift);

  // R4
  req_needed_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.shift |-> stepReq);
endmodule

// File: rtl/bsr_datapath.sv
module bsr_datapath
  import bsr_pkg::*;
#(
  parameter int WIDTH      = 5,
  parameter bit SHIFT_LEFT = 1'b0
) (
  input  logic             clk,
  input  bsrStrobe_t       strobe,
  input  logic             serialIn,
  output logic [WIDTH-1:0] wordQ,
  output logic             unloadQ
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] wordNext;
  logic             exitBit;

  generate
    if (SHIFT_LEFT) begin : g_left
      always_comb begin
        wordNext = {wordQ[MSB-1:0], serialIn};
        exitBit  = wordQ[MSB];
      end
      // R3
      left_move_chk: assert property (@(posedge clk) disable iff (strobe.clear)
        strobe.shift |=> (wordQ[MSB:1] == $past(wordQ[MSB-1:0]))
                         && (unloadQ == $past(wordQ[MSB]))
                         && (wordQ[0] == $past(serialIn)));
    end else begin : g_right
      always_comb begin
        wordNext = {serialIn, wordQ[MSB:1]};
        exitBit  = wordQ[0];
      end
      // R2
      right_move_chk: assert property (@(posedge clk) disable iff (strobe.clear)
        strobe.shift |=> (wordQ[MSB-1:0] == $past(wordQ[MSB:1]))
                         && (unloadQ == $past(wordQ[0]))
                         && (wordQ[MSB] == $past(serialIn)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      wordQ   <= '0;
      unloadQ <= 1'b0;
    end else if (strobe.shift) begin
      wordQ   <= wordNext;
      unloadQ <= exitBit;
    end
  end

  // R5 R7
  hold_state_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.shift |=> $stable(wordQ) && $stable(unloadQ));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    strobe.clear |=> (wordQ == '0) && !unloadQ);
endmodule

// File: rtl/edge_bit_shifter.sv
module edge_bit_shifter
  import bsr_pkg::*;
#(
  parameter int WIDTH      = 5,
  parameter bit SHIFT_LEFT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stepReq,
  input  logic             serialIn,
  output logic [WIDTH-1:0] parWord,
  output logic             unloadBit
);
  bsrStrobe_t strobe;

  bsr_control u_control (
    .clk     (clk),
    .rst     (rst),
    .stepReq (stepReq),
    .strobe  (strobe)
  );

  bsr_datapath #(
    .WIDTH      (WIDTH),
    .SHIFT_LEFT (SHIFT_LEFT)
  ) u_datapath (
    .clk      (clk),
    .strobe   (strobe),
    .serialIn (serialIn),
    .wordQ    (parWord),
    .unloadQ  (unloadBit)
  );
endmodule

// File: tb/edge_bit_shifter_bench.sv
module edge_bit_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 5;
  localparam int NVEC = 17;

  // Each vector: {stepReq, serialIn, expected word[4:0], expected unload}
  localparam logic [7:0] VECS [NVEC] = '{
    {2'b11, 5'b10000, 1'b0},  // R2 first shift
    {2'b10, 5'b10000, 1'b0},  // R4 held high
    {2'b01, 5'b10000, 1'b0},  // R5 ignored
    {2'b11, 5'b11000, 1'b0},
    {2'b00, 5'b11000, 1'b0},
    {2'b10, 5'b01100, 1'b0},
    {2'b00, 5'b01100, 1'b0},
    {2'b11, 5'b10110, 1'b0},
    {2'b01, 5'b10110, 1'b0},  // R5
    {2'b10, 5'b01011, 1'b0},
    {2'b00, 5'b01011, 1'b0},
    {2'b10, 5'b00101, 1'b1},  // R2 unload
    {2'b00, 5'b00101, 1'b1},  // R7
    {2'b11, 5'b10010, 1'b1},
    {2'b11, 5'b10010, 1'b1},  // R4
    {2'b00, 5'b10010, 1'b1},  // R7
    {2'b10, 5'b01001, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stepReq = 1'b0;
  logic serialIn = 1'b0;
  logic [W-1:0] wordR, wordL;
  logic unlR, unlL;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_bit_shifter #(.WIDTH(W), .SHIFT_LEFT(1'b0)) u_edge_bit_shifter (
    .clk(clk), .rst(rst), .stepReq(stepReq), .serialIn(serialIn),
    .parWord(wordR), .unloadBit(unlR));

  edge_bit_shifter #(.WIDTH(W), .SHIFT_LEFT(1'b1)) u_edge_bit_shifter_left (
    .clk(clk), .rst(rst), .stepReq(stepReq), .serialIn(serialIn),
    .parWord(wordL), .unloadBit(unlL));

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic cycle(input logic r, input logic s);
    @(negedge clk);
    stepReq = r;
    serialIn = s;
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(input logic s);
    cycle(1'b1, s);
    cycle(1'b0, s);
  endtask

  initial begin
    // R1: reset with request high, then release keeping it high
    stepReq = 1'b1;
    serialIn = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 word+unload after reset", {wordR, unlR}, 6'b000000);
    check("R1 left word+unload after reset", {wordL, unlL}, 6'b000000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 history cleared, shift after reset", {wordR, unlR}, 6'b100000);

    // Return to a clean state for the table
    @(negedge clk);
    rst = 1'b1;
    stepReq = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      cycle(VECS[i][7], VECS[i][6]);
      check($sformatf("R2/R4/R5/R7 vector %0d", i), {wordR, unlR}, VECS[i][5:0]);
    end

    // R6: a one reaches unload on the fifth shift after loading
    @(negedge clk);
    rst = 1'b1;
    stepReq = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    pulse(1'b1);
    for (int k = 0; k < 4; k++) pulse(1'b0);
    check("R6 not yet at unload after 4 shifts", {5'b0, unlR}, 6'b000000);
    pulse(1'b0);
    check("R6 at unload after 5 shifts", {5'b0, unlR}, 6'b000001);

    // R3: left direction
    @(negedge clk);
    rst = 1'b1;
    stepReq = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    pulse(1'b1);
    check("R3 left first bit at bit0", {wordL, unlL}, 6'b000010);
    pulse(1'b0);
    pulse(1'b1);
    check("R3 left after three shifts", {wordL, unlL}, 6'b001010);
    pulse(1'b0);
    pulse(1'b0);
    check("R3 left after five shifts", {wordL, unlL}, 6'b101000);
    pulse(1'b1);
    check("R3 R6 left MSB ejected", {wordL, unlL}, 6'b010011);
    cycle(1'b1, 1'b0);
    check("R3 R4 left second shift", {wordL, unlL}, 6'b100100);
    cycle(1'b1, 1'b1);
    check("R4 R5 R7 left held high", {wordL, unlL}, 6'b100100);

    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule